// File: doc/BRIEF.md
# Security-Aware Bus Protection Checker

This block is a bus filter placed between an AHB5-style interconnect and one memory or peripheral slave. Every transfer brings two attributes with it: a non-secure flag (`hnonsec`, 0 = secure, 1 = non-secure) and a privilege flag (`hpriv`, 1 = privileged). The address selects one of `NREG` target regions. Each region has a secure-only bit and a privileged-only bit. The checker compares the transfer's attributes with the bits of its region. It then either forwards the transfer to the slave unchanged or blocks it.

A blocked transfer never shows up on the downstream side. The checker answers it locally with the two-cycle AHB ERROR response. The block also raises a sticky violation flag, which drives an interrupt. Software clears the flag through the block's own small configuration window.

That configuration window is selected by `cfg_sel` and holds three word registers: the secure-only mask, the privileged-only mask and the status word. Only a transfer that is both secure and privileged may read or write the window. When the block sits in front of a peripheral bridge, it acts as the gate that passes or stops each transaction toward the peripheral side.

Top module: `sec_bus_gate`

## Requirements
- R1: After reset, every region is secure-only (secure mask all ones), no region is privileged-only (privilege mask zero), the status word and `irq` are 0, and `hreadyout` is 1 with `hresp` 0.
- R2: A transfer with `hnonsec`=1 aimed at a region whose secure-only bit is 1 is blocked. `m_hsel` and `m_htrans[1]` stay low in its address phase, so the slave never sees it.
- R3: A transfer with `hnonsec`=0 reaches regions whether or not they are secure-only. A transfer with `hnonsec`=1 reaches a region whose secure-only bit is 0, provided R4 does not block it.
- R4: A transfer with `hpriv`=0 aimed at a region whose privileged-only bit is 1 is blocked, even when it is secure.
- R5: A blocked transfer gets a two-cycle ERROR response. The first data-phase cycle has `hreadyout`=0 and `hresp`=1. The second has `hreadyout`=1 and `hresp`=1.
- R6: During the data phase of a blocked transfer, `hrdata` is 0 and `m_hwdata` is 0, so the slave's contents are unchanged.
- R7: The configuration window (`cfg_sel`=1) is decoded from `haddr[3:2]`. Word 0 is the secure mask (bit i belongs to region i). Word 1 is the privilege mask. Word 2 is the status word, with the violation flag in bit 0. An access by a non-secure or unprivileged transfer is blocked like R5, reads 0, and changes no register.
- R8: A blocked transfer sets the violation flag. `irq` rises at the clock edge that ends that transfer's address phase and stays high until a secure privileged write of 1 to status bit 0.
- R9: The region index is `haddr[REG_LSB+IDX_W-1:REG_LSB]`, which with the defaults is `haddr[14:12]`.
- R10: For a forwarded transfer, the slave's `m_hreadyout`, `m_hresp` and `m_hrdata` appear on `hreadyout`, `hresp` and `hrdata` in its data phase, including wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave target selected |
| cfg_sel | input | 1 | Configuration window selected |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size |
| hpriv | input | 1 | 1 = privileged transfer |
| hnonsec | input | 1 | 1 = non-secure, 0 = secure |
| hwdata | input | DATA_W | Write data |
| hready | input | 1 | Bus ready from interconnect |
| hreadyout | output | 1 | Ready toward interconnect |
| hresp | output | 1 | 1 = ERROR response |
| hrdata | output | DATA_W | Read data toward interconnect |
| irq | output | 1 | Sticky violation interrupt |
| m_hsel | output | 1 | Slave select downstream |
| m_haddr | output | ADDR_W | Address downstream |
| m_htrans | output | 2 | Transfer type downstream (IDLE when blocked) |
| m_hwrite | output | 1 | Write flag downstream |
| m_hsize | output | 3 | Size downstream |
| m_hpriv | output | 1 | Privilege flag downstream |
| m_hnonsec | output | 1 | Non-secure flag downstream |
| m_hwdata | output | DATA_W | Write data downstream (0 unless forwarding) |
| m_hready | output | 1 | Bus ready downstream |
| m_hreadyout | input | 1 | Slave ready |
| m_hresp | input | 1 | Slave response |
| m_hrdata | input | DATA_W | Slave read data |

## Verification
The allow-or-block decision is combinational in the address phase. The bench therefore checks the downstream `m_htrans`/`m_hsel` one time step after it drives the address, before the clock edge samples it. The violation flag and `irq` are registered on the edge that ends the address phase, so the bench checks them in the data phase that follows. For an ERROR response, the bench samples on the falling edge of the first data cycle, expecting ready low, and again one cycle later, expecting ready high. For a forwarded transfer, it counts the slave's wait cycles at falling edges and reads `hrdata` on the first falling edge where `hreadyout` is 1.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [2:0] {
        DP_IDLE = 3'd0,
        DP_PASS = 3'd1,
        DP_ERR1 = 3'd2,
        DP_ERR2 = 3'd3,
        DP_CFG  = 3'd4
    } dphase_e;

    typedef struct packed {
        dphase_e    st;
        logic       wr;
        logic [1:0] csel;
    } resp_s;

    localparam logic [1:0] TRANS_IDLE = 2'b00;
    localparam logic [1:0] CSEL_SEC   = 2'd0;
    localparam logic [1:0] CSEL_PRIV  = 2'd1;
    localparam logic [1:0] CSEL_STAT  = 2'd2;

endpackage

// File: rtl/sbg_decide.sv
module sbg_decide #(
    parameter int NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0] rgn,
    input  logic             nonsec,
    input  logic             priv,
    input  logic [NREG-1:0]  sec_mask,
    input  logic [NREG-1:0]  priv_mask,
    output logic             tgt_block,
    output logic             cfg_ok
);
    logic need_sec;
    logic need_priv;

    always_comb begin
        need_sec  = sec_mask[rgn];
        need_priv = priv_mask[rgn];
        // a secure transfer passes any security check; unprivileged fails privileged targets
        tgt_block = (nonsec && need_sec) || (!priv && need_priv);
        cfg_ok    = !nonsec && priv;
    end
endmodule

// File: rtl/sbg_cfg.sv
module sbg_cfg
    import sbg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wsel,
    input  logic [NREG-1:0] wdata,
    input  logic            viol_set,
    output logic [NREG-1:0] sec_mask,
    output logic [NREG-1:0] priv_mask,
    output logic            viol
);
    typedef struct packed {
        logic [NREG-1:0] sec;
        logic [NREG-1:0] prv;
        logic            viol;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic clr_req;

    always_comb begin
        cfg_d   = cfg_q;
        clr_req = wr_en && (wsel == CSEL_STAT) && wdata[0];
        if (wr_en) begin
            case (wsel)
                CSEL_SEC:  cfg_d.sec = wdata;
                CSEL_PRIV: cfg_d.prv = wdata;
                default:   ;
            endcase
        end
        if (clr_req)  cfg_d.viol = 1'b0;
        if (viol_set) cfg_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sec  <= '1;
            cfg_q.prv  <= '0;
            cfg_q.viol <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sec_mask  = cfg_q.sec;
    assign priv_mask = cfg_q.prv;
    assign viol      = cfg_q.viol;

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.viol && !clr_req) |=> cfg_q.viol); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_q.sec) && $stable(cfg_q.prv))); // R7
endmodule

// File: rtl/sbg_resp.sv
module sbg_resp
    import sbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hready,
    input  logic       acc_any,
    input  logic       acc_block,
    input  logic       acc_cfg,
    input  logic       acc_write,
    input  logic [1:0] acc_csel,
    output dphase_e    st,
    output logic       dp_write,
    output logic [1:0] dp_csel
);
    resp_s rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (rs_q.st == DP_ERR1) begin
            rs_d.st = DP_ERR2;
        end else if (hready) begin
            if (acc_any) begin
                if (acc_block)    rs_d.st = DP_ERR1;
                else if (acc_cfg) rs_d.st = DP_CFG;
                else              rs_d.st = DP_PASS;
                rs_d.wr   = acc_write;
                rs_d.csel = acc_csel;
            end else begin
                rs_d.st = DP_IDLE;
                rs_d.wr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q.st   <= DP_IDLE;
            rs_q.wr   <= 1'b0;
            rs_q.csel <= 2'd0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign st       = rs_q.st;
    assign dp_write = rs_q.wr;
    assign dp_csel  = rs_q.csel;
endmodule

// File: rtl/sec_bus_gate.sv
module sec_bus_gate
    import sbg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NREG    = 8,
    parameter int REG_LSB = 12,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic              hpriv,
    input  logic              hnonsec,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              irq,
    output logic              m_hsel,
    output logic [ADDR_W-1:0] m_haddr,
    output logic [1:0]        m_htrans,
    output logic              m_hwrite,
    output logic [2:0]        m_hsize,
    output logic              m_hpriv,
    output logic              m_hnonsec,
    output logic [DATA_W-1:0] m_hwdata,
    output logic              m_hready,
    input  logic              m_hreadyout,
    input  logic              m_hresp,
    input  logic [DATA_W-1:0] m_hrdata
);
    logic [IDX_W-1:0] rgn;
    logic [NREG-1:0]  sec_mask, priv_mask;
    logic             tgt_block, cfg_ok;
    logic             acc_any, acc_block, viol, cfg_wr_en, fwd;
    dphase_e          st;
    logic             dp_write;
    logic [1:0]       dp_csel;
    logic [DATA_W-1:0] cfg_rdata;

    assign rgn = haddr[REG_LSB +: IDX_W];

    sbg_decide #(.NREG(NREG)) u_decide (
        .rgn       (rgn),
        .nonsec    (hnonsec),
        .priv      (hpriv),
        .sec_mask  (sec_mask),
        .priv_mask (priv_mask),
        .tgt_block (tgt_block),
        .cfg_ok    (cfg_ok)
    );

    always_comb begin
        acc_any   = hready && htrans[1] && (hsel || cfg_sel) && (st != DP_ERR1);
        acc_block = cfg_sel ? !cfg_ok : tgt_block;
        cfg_wr_en = (st == DP_CFG) && dp_write && hready;
        fwd       = hsel && !cfg_sel && !tgt_block;
    end

    sbg_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .acc_any   (acc_any),
        .acc_block (acc_block),
        .acc_cfg   (cfg_sel),
        .acc_write (hwrite),
        .acc_csel  (haddr[3:2]),
        .st        (st),
        .dp_write  (dp_write),
        .dp_csel   (dp_csel)
    );

    sbg_cfg #(.NREG(NREG)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wsel      (dp_csel),
        .wdata     (hwdata[NREG-1:0]),
        .viol_set  (acc_any && acc_block),
        .sec_mask  (sec_mask),
        .priv_mask (priv_mask),
        .viol      (viol)
    );

    always_comb begin
        case (dp_csel)
            CSEL_SEC:  cfg_rdata = DATA_W'(sec_mask);
            CSEL_PRIV: cfg_rdata = DATA_W'(priv_mask);
            CSEL_STAT: cfg_rdata = DATA_W'(viol);
            default:   cfg_rdata = '0;
        endcase
    end

    // downstream side
    always_comb begin
        m_hsel    = fwd;
        m_htrans  = fwd ? htrans : TRANS_IDLE;
        m_haddr   = haddr;
        m_hwrite  = hwrite;
        m_hsize   = hsize;
        m_hpriv   = hpriv;
        m_hnonsec = hnonsec;
        m_hready  = hready;
        m_hwdata  = (st == DP_PASS) ? hwdata : '0;
    end

    // upstream response
    always_comb begin
        case (st)
            DP_PASS: begin
                hreadyout = m_hreadyout;
                hresp     = m_hresp;
                hrdata    = m_hrdata;
            end
            DP_ERR1: begin
                hreadyout = 1'b0;
                hresp     = 1'b1;
                hrdata    = '0;
            end
            DP_ERR2: begin
                hreadyout = 1'b1;
                hresp     = 1'b1;
                hrdata    = '0;
            end
            DP_CFG: begin
                hreadyout = 1'b1;
                hresp     = 1'b0;
                hrdata    = dp_write ? '0 : cfg_rdata;
            end
            default: begin
                hreadyout = 1'b1;
                hresp     = 1'b0;
                hrdata    = '0;
            end
        endcase
    end

    assign irq = viol;

    AST_NS_NEVER_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && m_hsel && m_htrans[1]) |-> !(hnonsec && sec_mask[rgn])); // R2
    AST_UNPRIV_NEVER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && m_hsel && m_htrans[1]) |-> !(!hpriv && priv_mask[rgn])); // R4
    AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout)); // R5
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == DP_ERR1) || (st == DP_ERR2)) |-> (m_hwdata == '0 && hrdata == '0)); // R6
endmodule

// File: tb/sec_bus_gate_tb_top.sv
`timescale 1ns/1ps
module sec_bus_gate_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        hsel = 0, cfg_sel = 0, hwrite = 0, hpriv = 0, hnonsec = 0;
    logic [31:0] haddr = 0, hwdata = 0;
    logic [1:0]  htrans = 0;
    logic [2:0]  hsize = 3'd2;
    logic        hready, hreadyout, hresp, irq;
    logic [31:0] hrdata;
    logic        m_hsel, m_hwrite, m_hpriv, m_hnonsec, m_hready, m_hreadyout, m_hresp;
    logic [31:0] m_haddr, m_hwdata, m_hrdata;
    logic [1:0]  m_htrans;
    logic [2:0]  m_hsize;

    assign hready = hreadyout;

    sec_bus_gate dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .cfg_sel(cfg_sel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hpriv(hpriv),
        .hnonsec(hnonsec), .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata), .irq(irq), .m_hsel(m_hsel), .m_haddr(m_haddr),
        .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize), .m_hpriv(m_hpriv),
        .m_hnonsec(m_hnonsec), .m_hwdata(m_hwdata), .m_hready(m_hready),
        .m_hreadyout(m_hreadyout), .m_hresp(m_hresp), .m_hrdata(m_hrdata)
    );

    // ---------------- slave model ----------------
    logic [31:0] smem [32];
    logic        s_act = 0, s_wr = 0;
    logic [4:0]  s_idx = 0;
    int          s_wait = 0;
    int          next_wait = 0;
    int          slave_hits = 0;

    assign m_hreadyout = !s_act || (s_wait == 0);
    assign m_hresp     = 1'b0;
    assign m_hrdata    = (s_act && !s_wr) ? smem[s_idx] : 32'h0;

    always @(posedge clk) begin
        if (m_hready) begin
            if (s_act && s_wr) smem[s_idx] <= m_hwdata;
            s_act <= m_hsel && m_htrans[1];
            s_wr  <= m_hwrite;
            s_idx <= {m_haddr[14:12], m_haddr[3:2]};
            s_wait <= next_wait;
            if (m_hsel && m_htrans[1]) slave_hits <= slave_hits + 1;
        end else if (s_act && s_wait > 0) begin
            s_wait <= s_wait - 1;
        end
    end

    // ---------------- scoreboard ----------------
    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] ref_mem [32];
    logic [7:0]  ref_sec = 8'hFF, ref_prv = 8'h00;
    bit          ref_viol = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_block(bit cfg, bit ns, bit pv, int rg);
        if (cfg) return ns || !pv;
        return (ns && ref_sec[rg]) || (!pv && ref_prv[rg]);
    endfunction

    // one non-pipelined transfer
    task automatic xfer(input bit cfg, input bit wr, input logic [31:0] addr,
                        input logic [31:0] data, input bit ns, input bit pv, input int waitn,
                        output logic [31:0] rd, output bit err, output bit fwd,
                        output int waits, output bit first_err, output bit wd_clean);
        @(negedge clk);
        hsel = !cfg; cfg_sel = cfg; haddr = addr; htrans = 2'b10; hwrite = wr;
        hnonsec = ns; hpriv = pv; next_wait = waitn;
        #1;
        fwd = m_hsel && m_htrans[1];
        @(negedge clk);
        hsel = 0; cfg_sel = 0; htrans = 2'b00; hwdata = data;
        waits = 0; wd_clean = 1; first_err = hresp && !hreadyout;
        while (!hreadyout) begin
            if (m_hwdata != 0) wd_clean = 0;
            @(negedge clk);
            waits++;
        end
        if (m_hwdata != 0 && hresp) wd_clean = 0;
        rd = hrdata; err = hresp;
        @(posedge clk); #1; hwdata = 0;
    endtask

    // runs a transfer and checks it against the reference model
    task automatic run(input bit cfg, input bit wr, input int rg, input int wd,
                       input logic [31:0] data, input bit ns, input bit pv, input int waitn);
        logic [31:0] addr, rd, exp_rd;
        bit err, fwd, fe, wdc, blk;
        int waits, hits0, idx;
        addr = cfg ? (wd << 2) : ((rg << 12) | (wd << 2));
        idx = rg * 4 + wd;
        blk = exp_block(cfg, ns, pv, rg);
        hits0 = slave_hits;
        exp_rd = 0;
        if (!blk && !wr) begin
            if (!cfg) exp_rd = ref_mem[idx];
            else if (wd == 0) exp_rd = {24'h0, ref_sec};
            else if (wd == 1) exp_rd = {24'h0, ref_prv};
            else if (wd == 2) exp_rd = {31'h0, ref_viol};
        end
        xfer(cfg, wr, addr, data, ns, pv, waitn, rd, err, fwd, waits, fe, wdc);
        if (blk) begin
            ref_viol = 1;
            chk(err && fe && waits == 1, "R5 error response shape", {30'h0, fe, err}, 32'h3);
            chk(!fwd && slave_hits == hits0, "R2/R4 blocked not forwarded", {31'h0, fwd}, 0);
            chk(rd == 0 && wdc, "R6 blocked data zero", rd, 0);
        end else begin
            chk(!err, "R3 allowed transfer OKAY", {31'h0, err}, 0);
            if (!cfg) begin
                chk(fwd && slave_hits == hits0 + 1, "R3 forwarded to slave", {31'h0, fwd}, 1);
                chk(waits == waitn, "R10 wait states passed", waits, waitn);
                if (wr) ref_mem[idx] = data;
            end else if (wr) begin
                if (wd == 0) ref_sec = data[7:0];
                else if (wd == 1) ref_prv = data[7:0];
                else if (wd == 2 && data[0]) ref_viol = 0;
            end
            if (!wr) chk(rd == exp_rd, cfg ? "R7 config read" : "R10 read data", rd, exp_rd);
        end
        chk(irq == ref_viol, "R8 irq state", {31'h0, irq}, {31'h0, ref_viol});
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin smem[i] = 0; ref_mem[i] = 0; end
        void'($urandom(32'h5EC0_0017));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(irq == 0 && hreadyout && !hresp, "R1 reset outputs", {29'h0, irq, hreadyout, hresp}, 32'h2);
        run(1, 0, 0, 0, 0, 0, 1, 0);          // R1 secure mask reads FF
        run(1, 0, 0, 1, 0, 0, 1, 0);          // R1 privilege mask reads 0
        run(1, 0, 0, 2, 0, 0, 1, 0);          // R1 status 0
        // R2: non-secure into default-secure region 3
        run(0, 1, 3, 1, 32'hDEAD_BEEF, 1, 1, 0);
        run(0, 0, 3, 1, 0, 1, 1, 0);          // R6 blocked read
        run(0, 0, 3, 1, 0, 0, 1, 0);          // R6 memory untouched, read 0 securely
        run(0, 1, 3, 1, 32'h1234_5678, 0, 1, 0); // R3 secure write
        run(0, 0, 3, 1, 0, 0, 0, 1);          // R3 secure unprivileged read, wait 1
        // R7: rejected config accesses
        run(1, 1, 0, 0, 32'h0, 1, 1, 0);
        run(1, 1, 0, 0, 32'h0, 0, 0, 0);
        run(1, 1, 0, 2, 32'h1, 1, 1, 0);      // R8 clear by non-secure ignored
        run(1, 0, 0, 0, 0, 0, 1, 0);          // R7 mask unchanged
        run(1, 1, 0, 2, 32'h1, 0, 1, 0);      // R8 clear
        run(1, 1, 0, 0, 32'hF0, 0, 1, 0);     // regions 0..3 non-secure
        run(1, 1, 0, 1, 32'h0C, 0, 1, 0);     // regions 2,3 privileged-only
        run(0, 1, 1, 0, 32'hA5A5_0001, 1, 1, 0); // R3 non-secure to non-secure region
        run(0, 1, 2, 0, 32'hA5A5_0002, 1, 0, 0); // R4 unprivileged to privileged region
        run(0, 1, 2, 0, 32'hA5A5_0003, 0, 0, 0); // R4 secure but unprivileged
        run(0, 0, 4, 0, 0, 1, 1, 0);          // R9 region 4 (haddr[14:12]=4) still secure
        run(0, 0, 1, 0, 0, 1, 1, 2);          // R10 two wait states, R9 region 1
        run(1, 1, 0, 2, 32'h1, 0, 1, 0);
        for (int n = 0; n < 300; n++) begin
            int sel = $urandom_range(0, 9);
            if (sel == 0) begin
                run(1, 1, 0, $urandom_range(0, 2), $urandom, $urandom_range(0, 1),
                    $urandom_range(0, 1), 0);
            end else if (sel == 1) begin
                run(1, 0, 0, $urandom_range(0, 2), 0, $urandom_range(0, 1),
                    $urandom_range(0, 1), 0);
            end else begin
                run(0, $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
                    $urandom, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2));
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule